// File: doc/BRIEF.md
# Isolated Digital I/O Port Register Block

This block is the register window of a board with sixteen digital outputs and sixteen digital inputs, attached to a simple byte-wide bus with a three-bit offset, write data, read data and separate read and write strobes. Each strobe is a single-cycle pulse that is sampled on the rising clock edge. The outputs are held in two byte latches that software can only write. The inputs can only be read, as two bytes. They pass through a synchroniser before the bus sees them.

Any level change on any input, rising or falling, can raise a shared interrupt request. Software controls that interrupt through access side effects only. A read of offset 2 arms the interrupt, and a write to offset 2 disarms it. A write to offset 1 acknowledges a pending change. The data byte is ignored in all three cases.

Top module: `isoio_regblock`

## Requirements
- R1: A write to offset 0 loads `outPins[7:0]` and a write to offset 4 loads `outPins[15:8]` from `busWrData`, visible after that clock edge. The other byte is left unchanged.
- R2: A read of offset 1 returns input bits 7..0, and a read of offset 5 returns input bits 15..8. The value is the input as it stood two clock edges earlier (two-flop synchroniser), and `busRdData` is combinational from `busAddr`.
- R3: A read of any other offset (0, 2, 3, 4, 6, 7) returns 0xFF. Output latch contents are never read back.
- R4: A read strobe at offset 2 enables the interrupt and a write strobe at offset 2 disables it, whatever the data. If both strobes occur at offset 2 in one cycle, the write wins.
- R5: While the interrupt is enabled, a rising or falling edge on any synchronised input bit sets the pending flag one edge after the new value becomes readable. `irqReq` is high while the flag is set and the interrupt is enabled.
- R6: A write to offset 1, with any data, clears the pending flag.
- R7: While the interrupt is disabled, input edges are not recorded. A pending flag set earlier is kept, and it reappears on `irqReq` when the interrupt is enabled again.
- R8: If a clearing write coincides with a newly detected edge while enabled, the pending flag stays set.
- R9: After reset the outputs are 0x0000, the interrupt is disabled and nothing is pending.
- R10: Writes to offsets 1, 2, 3, 5, 6 and 7 leave `outPins` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Offset within the 8-byte window |
| busWrData | input | 8 | Write data byte |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busRdData | output | 8 | Read data byte (combinational) |
| inPins | input | 16 | Raw digital inputs |
| outPins | output | 16 | Output latch contents |
| irqReq | output | 1 | Level interrupt request |

## Verification
The bench drives every stimulus at a falling edge and samples at later falling edges, which places each check exactly in the cycle the result is due. Write effects on the outputs and on interrupt enable are checked one edge after the strobe. Read data is sampled within the same cycle as the address. A new input value is checked two edges after it is applied. The interrupt is checked to be still low at that point and high one edge later. The test for R8 places the clearing write on the third edge after the input change, which is the edge on which the new change is recorded.

// File: rtl/isoio_pkg.sv
package isoio_pkg;
  parameter int BYTE_W     = 8;
  parameter int PORT_BYTES = 2;
  parameter int ADDR_W     = 3;
  localparam int PORT_W    = BYTE_W * PORT_BYTES;

  // Offsets whose behaviour is fixed by the bus protocol
  localparam logic [ADDR_W-1:0] OFS_OUT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IN_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IRQ_EN = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_OUT_HI = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_IN_HI  = 3'd5;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_IN_LO = 2'd1,
    RD_IN_HI = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic wrOutLo;
    logic wrOutHi;
    logic irqArm;
    logic irqDisarm;
    logic pendAck;
  } ctrlStrobes_t;
endpackage

// File: rtl/isoio_ctrl.sv
module isoio_ctrl
  import isoio_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output ctrlStrobes_t      strobes,
  output rdSel_e            rdSel
);
  always_comb begin
    strobes           = '0;
    strobes.wrOutLo   = busWr && (busAddr == OFS_OUT_LO);
    strobes.wrOutHi   = busWr && (busAddr == OFS_OUT_HI);
    strobes.pendAck   = busWr && (busAddr == OFS_IN_LO);
    strobes.irqDisarm = busWr && (busAddr == OFS_IRQ_EN);
    strobes.irqArm    = busRd && (busAddr == OFS_IRQ_EN);
  end

  always_comb begin
    unique case (busAddr)
      OFS_IN_LO: rdSel = RD_IN_LO;
      OFS_IN_HI: rdSel = RD_IN_HI;
      default:   rdSel = RD_IDLE;
    endcase
  end
endmodule

// File: rtl/isoio_datapath.sv
module isoio_datapath
  import isoio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  rdSel_e            rdSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [PORT_W-1:0] inPins,
  output logic [PORT_W-1:0] outPins,
  output logic [BYTE_W-1:0] rdData,
  output logic              irqReq,
  output logic              irqEn,
  output logic              pendFlag
);
  logic [SYNC_STAGES-1:0][PORT_W-1:0] syncChain;
  logic [PORT_W-1:0] syncedIn;
  logic [PORT_W-1:0] prevSample;
  logic              anyEdge;

  // Output byte latches
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outPins <= '0;
    end else begin
      if (strobes.wrOutLo) outPins[BYTE_W-1:0]      <= wrData;
      if (strobes.wrOutHi) outPins[PORT_W-1:BYTE_W] <= wrData;
    end
  end

  // Synchroniser chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rst_n) syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= inPins;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncedIn = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prevSample <= '0;
    else        prevSample <= syncedIn;
  end

  assign anyEdge = |(syncedIn ^ prevSample);

  // Interrupt enable: disarm wins over arm
  always_ff @(posedge clk) begin
    if (!rst_n)                 irqEn <= 1'b0;
    else if (strobes.irqDisarm) irqEn <= 1'b0;
    else if (strobes.irqArm)    irqEn <= 1'b1;
  end

  // Pending flag: a new edge beats an acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n)                pendFlag <= 1'b0;
    else if (anyEdge && irqEn) pendFlag <= 1'b1;
    else if (strobes.pendAck)  pendFlag <= 1'b0;
  end

  assign irqReq = pendFlag && irqEn;

  always_comb begin
    unique case (rdSel)
      RD_IN_LO: rdData = syncedIn[BYTE_W-1:0];
      RD_IN_HI: rdData = syncedIn[PORT_W-1:BYTE_W];
      default:  rdData = '1;
    endcase
  end
endmodule

// File: rtl/isoio_regblock.sv
module isoio_regblock
  import isoio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [BYTE_W-1:0] busRdData,
  input  logic [PORT_W-1:0] inPins,
  output logic [PORT_W-1:0] outPins,
  output logic              irqReq
);
  ctrlStrobes_t strobes;
  rdSel_e       rdSel;
  logic         irqEn;
  logic         pendFlag;

  isoio_ctrl ctrl_i (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  isoio_datapath #(.SYNC_STAGES(2)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .wrData   (busWrData),
    .inPins   (inPins),
    .outPins  (outPins),
    .rdData   (busRdData),
    .irqReq   (irqReq),
    .irqEn    (irqEn),
    .pendFlag (pendFlag)
  );
endmodule

// File: rtl/isoio_checker.sv
module isoio_checker
  import isoio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BYTE_W-1:0] busWrData,
  input logic              busWr,
  input logic              busRd,
  input logic [PORT_W-1:0] outPins,
  input logic              irqReq,
  input logic              irqEn,
  input logic              pendFlag
);
  a_r1_out_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == 3'd0) |=> outPins[7:0] == $past(busWrData));

  a_r1_out_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == 3'd4) |=> outPins[15:8] == $past(busWrData));

  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(busWr && (busAddr == 3'd0 || busAddr == 3'd4))) |=> $stable(outPins));

  a_r4_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (busRd && busAddr == 3'd2 && !busWr) |=> irqEn);

  a_r4_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == 3'd2) |=> !irqEn);

  a_r7_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pendFlag) |-> $past(irqEn));

  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (pendFlag && irqEn));
endmodule

bind isoio_regblock isoio_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busWr     (busWr),
  .busRd     (busRd),
  .outPins   (outPins),
  .irqReq    (irqReq),
  .irqEn     (irqEn),
  .pendFlag  (pendFlag)
);

// File: tb/isoio_regblock_tb.sv
module isoio_regblock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdData;
  logic [15:0] inPins = '0;
  logic [15:0] outPins;
  logic        irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  isoio_regblock dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .inPins(inPins), .outPins(outPins), .irqReq(irqReq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitEdges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    check("R9 outputs", outPins, 16'h0000);
    check("R9 irq", irqReq, 1'b0);
  endtask

  task automatic testOutputs();
    busWrite(3'd0, 8'hA5);
    check("R1 low byte", outPins, 16'h00A5);
    busWrite(3'd4, 8'h3C);
    check("R1 high byte", outPins, 16'h3CA5);
  endtask

  task automatic testNoEffectWrites();
    logic [2:0] ofs [6] = '{3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 3'd7};
    foreach (ofs[i]) begin
      busWrite(ofs[i], 8'h00);
      check("R10 outputs held", outPins, 16'h3CA5);
    end
  endtask

  task automatic testFillReads();
    logic [7:0] d;
    logic [2:0] ofs [6] = '{3'd0, 3'd4, 3'd3, 3'd6, 3'd7, 3'd2};
    foreach (ofs[i]) begin
      busRead(ofs[i], d);
      check("R3 fill read", d, 8'hFF);
    end
    busWrite(3'd2, 8'h00);
  endtask

  task automatic testInputs();
    logic [7:0] d;
    inPins = 16'h1234;
    waitEdges(2);
    busRead(3'd1, d);
    check("R2 low input byte", d, 8'h34);
    busRead(3'd5, d);
    check("R2 high input byte", d, 8'h12);
  endtask

  task automatic testDisabledEdges();
    logic [7:0] d;
    inPins = 16'hFFFF;
    waitEdges(4);
    busRead(3'd2, d);
    waitEdges(2);
    check("R7 edge while disabled not recorded", irqReq, 1'b0);
  endtask

  task automatic testEdgesAndClear();
    inPins = 16'hFFFE;
    waitEdges(2);
    check("R5 irq not yet raised", irqReq, 1'b0);
    waitEdges(1);
    check("R5 falling edge raises irq", irqReq, 1'b1);
    busWrite(3'd1, 8'hFF);
    check("R6 clear", irqReq, 1'b0);
    inPins = 16'hFFFF;
    waitEdges(3);
    check("R5 rising edge raises irq", irqReq, 1'b1);
  endtask

  task automatic testEnableControl();
    logic [7:0] d;
    busWrite(3'd2, 8'hFF);
    check("R4 write disables", irqReq, 1'b0);
    busRead(3'd2, d);
    check("R7 pending kept while disabled", irqReq, 1'b1);
    busWrite(3'd1, 8'h00);
    check("R6 clear with zero data", irqReq, 1'b0);
    busAddr = 3'd2; busRd = 1'b1; busWr = 1'b1;
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0;
    inPins = 16'h7FFF;
    waitEdges(3);
    check("R4 write wins over read", irqReq, 1'b0);
    busRead(3'd2, d);
    check("R4 read re-enables", irqReq, 1'b0);
  endtask

  task automatic testClearRace();
    inPins = 16'hFFFF;
    waitEdges(3);
    check("R5 pending before race", irqReq, 1'b1);
    inPins = 16'h7FFF;
    waitEdges(2);
    busWrite(3'd1, 8'h00);
    check("R8 edge beats clear", irqReq, 1'b1);
    busWrite(3'd1, 8'h00);
    check("R6 clear after race", irqReq, 1'b0);
  endtask

  initial begin
    waitEdges(3);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testOutputs();
    testNoEffectWrites();
    testFillReads();
    testInputs();
    testDisabledEdges();
    testEdgesAndClear();
    testEnableControl();
    testClearRace();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule